// File: doc/BRIEF.md
# Ethernet Controller Bring-Up Sequencer

This block sits on the host side of an Ethernet controller that exposes its control registers only through an indirect port. A register number is written first, and a data write or a data read follows it. After a single `go` strobe the sequencer walks the controller through a fixed bring-up order:

1. It halts the controller and confirms the halt by reading it back.
2. It hands over the two halves of the masked initialization-block address.
3. It programs the bus-control register.
4. It starts initialization.
5. It polls for the completion flag, up to a bounded number of tries.
6. When the flag appears, it acknowledges the flag and starts the controller in one write.

The block reports the outcome with a one-cycle `done` pulse and a two-bit result code. A driver or a boot state machine triggers it once after the initialization block has been placed in shared memory. Building that block and the controller itself lie outside this design.

Top module: `nic_bringup_seq`

## Requirements
- R1: After reset the block is idle: `busy` and `done` are 0 and none of `port_addr_we`, `port_data_we`, `port_data_re` is asserted.
- R2: Every register access takes two cycles. The first is a select cycle with `port_addr_we`=1 and the register number in `port_wdata[1:0]`, upper bits 0. The next cycle is either a write cycle (`port_data_we`=1, value on `port_wdata`) or a read cycle (`port_data_re`=1). Read data on `port_rdata` is taken in the cycle after the read strobe. At most one strobe is high in any cycle.
- R3: The first accesses are a write of 0x0004 to register 0 followed by a read of register 0. If the read value is not exactly 0x0004, the sequence ends with result code 1 and makes no further access.
- R4: Register 1 is then written with bits 15:0 of `init_addr` AND `ADDR_MASK`, and register 2 with bits 31:16 of that masked value. With the default mask 0x0000FFFF, register 2 receives 0.
- R5: Register 3 is then written with 0x0002, and after that register 0 is written with 0x0001.
- R6: Register 0 is then read repeatedly. Only bit 8 of the read value decides completion; every other bit is ignored.
- R7: If bit 8 is not seen in `POLL_LIMIT` (100) consecutive reads, the sequence ends with result code 2, after exactly 100 poll reads and no further access.
- R8: When bit 8 is seen, register 0 is written with 0x0102 and the sequence ends with result code 0.
- R9: `done` is high for exactly one cycle at the end of each sequence, and `err_code` carries the result in that cycle.
- R10: A `go` pulse while `busy` is 1 has no effect: the access order and the number of `done` pulses stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Starts a bring-up sequence when idle |
| init_addr | input | 32 | Initialization-block address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 success, 1 halt not confirmed, 2 completion timeout |
| port_addr_we | output | 1 | Register-select strobe |
| port_data_we | output | 1 | Data write strobe |
| port_data_re | output | 1 | Data read strobe |
| port_wdata | output | 16 | Register number or write data |
| port_rdata | input | 16 | Read data, valid one cycle after the read strobe |

## Verification
The assertions take for granted that the controller model holds `port_rdata` steady through the sample cycle after each read strobe. They also assume that `go` is sampled only on clock edges. The bench meets both conditions: it updates read data only on the edge that follows a read strobe, and it changes `go` only on falling edges. The bound on reads per sequence holds only because the checker clears its counter whenever the block is idle. The bench therefore always waits for `done` before it starts the next sequence.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  localparam int DW = 16;
  localparam int RW = 2;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_XFER, S_SAMPLE, S_FIN} nbs_state_t;
  typedef logic [2:0] step_t;

  localparam step_t ST_HALT = 3'd0;
  localparam step_t ST_CHK  = 3'd1;
  localparam step_t ST_LO   = 3'd2;
  localparam step_t ST_HI   = 3'd3;
  localparam step_t ST_BUS  = 3'd4;
  localparam step_t ST_INIT = 3'd5;
  localparam step_t ST_POLL = 3'd6;
  localparam step_t ST_RUN  = 3'd7;

  localparam logic [DW-1:0] V_HALT = 16'h0004;
  localparam logic [DW-1:0] V_BUS  = 16'h0002;
  localparam logic [DW-1:0] V_INIT = 16'h0001;
  localparam logic [DW-1:0] V_RUN  = 16'h0102;
  localparam int            B_IDONE = 8;

  localparam logic [1:0] RC_OK      = 2'd0;
  localparam logic [1:0] RC_HALTBAD = 2'd1;
  localparam logic [1:0] RC_TIMEOUT = 2'd2;

  // register number addressed by each step
  function automatic logic [RW-1:0] step_reg(step_t s);
    case (s)
      ST_LO:   return 2'd1;
      ST_HI:   return 2'd2;
      ST_BUS:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic step_reads(step_t s);
    return (s == ST_CHK) || (s == ST_POLL);
  endfunction

  // half of the masked block address
  function automatic logic [DW-1:0] addr_half(logic [31:0] a, logic [31:0] m, logic hi);
    logic [31:0] x;
    x = a & m;
    return hi ? x[31:16] : x[15:0];
  endfunction

  function automatic logic [DW-1:0] step_value(step_t s, logic [31:0] a, logic [31:0] m);
    case (s)
      ST_HALT: return V_HALT;
      ST_LO:   return addr_half(a, m, 1'b0);
      ST_HI:   return addr_half(a, m, 1'b1);
      ST_BUS:  return V_BUS;
      ST_INIT: return V_INIT;
      ST_RUN:  return V_RUN;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/nbs_step_table.sv
module nbs_step_table
  import nbs_pkg::*;
#(
  parameter logic [31:0] ADDR_MASK = 32'h0000_FFFF
) (
  input  step_t          step,
  input  logic [31:0]    init_addr,
  output logic [RW-1:0]  reg_idx,
  output logic [DW-1:0]  wvalue,
  output logic           is_read
);
  always_comb begin
    reg_idx = step_reg(step);
    wvalue  = step_value(step, init_addr, ADDR_MASK);
    is_read = step_reads(step);
  end
endmodule

// File: rtl/nbs_poll_limiter.sv
module nbs_poll_limiter #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic miss,
  output logic last_try
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (miss)       cnt <= cnt + 1'b1;
  end

  assign last_try = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/nbs_fsm.sv
module nbs_fsm
  import nbs_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [RW-1:0]  reg_idx,
  input  logic [DW-1:0]  wvalue,
  input  logic           is_read,
  input  logic           last_try,
  input  logic [DW-1:0]  rdata,
  output step_t          step,
  output logic           start,
  output logic           halt_bad,
  output logic           poll_miss,
  output logic           poll_hit,
  output logic           busy,
  output logic           done,
  output logic [1:0]     err_code,
  output logic           addr_we,
  output logic           data_we,
  output logic           data_re,
  output logic [DW-1:0]  wdata
);
  nbs_state_t state;

  assign start     = (state == S_IDLE) && go;
  assign halt_bad  = (state == S_SAMPLE) && (step == ST_CHK) && (rdata != V_HALT);
  assign poll_hit  = (state == S_SAMPLE) && (step == ST_POLL) && rdata[B_IDONE];
  assign poll_miss = (state == S_SAMPLE) && (step == ST_POLL) && !rdata[B_IDONE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      step     <= ST_HALT;
      err_code <= RC_OK;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          state <= S_SEL;
          step  <= ST_HALT;
        end
        S_SEL: state <= S_XFER;
        S_XFER: begin
          if (is_read) state <= S_SAMPLE;
          else if (step == ST_RUN) begin
            state    <= S_FIN;
            err_code <= RC_OK;
          end else begin
            state <= S_SEL;
            step  <= step + 3'd1;
          end
        end
        S_SAMPLE: begin
          if (halt_bad) begin
            state    <= S_FIN;
            err_code <= RC_HALTBAD;
          end else if (poll_miss && last_try) begin
            state    <= S_FIN;
            err_code <= RC_TIMEOUT;
          end else begin
            state <= S_SEL;
            if (!poll_miss) step <= step + 3'd1;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy    = (state != S_IDLE);
    done    = (state == S_FIN);
    addr_we = (state == S_SEL);
    data_we = (state == S_XFER) && !is_read;
    data_re = (state == S_XFER) && is_read;
    if (addr_we)      wdata = {{(DW-RW){1'b0}}, reg_idx};
    else if (data_we) wdata = wvalue;
    else              wdata = '0;
  end
endmodule

// File: rtl/nic_bringup_seq.sv
module nic_bringup_seq
  import nbs_pkg::*;
#(
  parameter int          POLL_LIMIT = 100,
  parameter logic [31:0] ADDR_MASK  = 32'h0000_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [31:0] init_addr,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err_code,
  output logic        port_addr_we,
  output logic        port_data_we,
  output logic        port_data_re,
  output logic [15:0] port_wdata,
  input  logic [15:0] port_rdata
);
  step_t          step;
  logic [RW-1:0]  reg_idx;
  logic [DW-1:0]  wvalue;
  logic           is_read;
  logic           last_try;
  logic           start;
  logic           halt_bad;
  logic           poll_miss;
  logic           poll_hit;

  nbs_step_table #(.ADDR_MASK(ADDR_MASK)) u_table (
    .step(step), .init_addr(init_addr),
    .reg_idx(reg_idx), .wvalue(wvalue), .is_read(is_read)
  );

  nbs_poll_limiter #(.LIMIT(POLL_LIMIT)) u_limit (
    .clk(clk), .rst_n(rst_n), .clear(start),
    .miss(poll_miss), .last_try(last_try)
  );

  nbs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go),
    .reg_idx(reg_idx), .wvalue(wvalue), .is_read(is_read),
    .last_try(last_try), .rdata(port_rdata),
    .step(step), .start(start), .halt_bad(halt_bad),
    .poll_miss(poll_miss), .poll_hit(poll_hit),
    .busy(busy), .done(done), .err_code(err_code),
    .addr_we(port_addr_we), .data_we(port_data_we),
    .data_re(port_data_re), .wdata(port_wdata)
  );
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
  parameter int POLL_LIMIT = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       busy,
  input logic       done,
  input logic [1:0] err_code,
  input logic       addr_we,
  input logic       data_we,
  input logic       data_re,
  input logic       halt_bad,
  input logic       poll_hit
);
  logic [15:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) rd_cnt <= '0;
    else if (data_re)    rd_cnt <= rd_cnt + 16'd1;
  end

  // R1: idle means a quiet port
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(addr_we || data_we || data_re));
  // R2: one strobe per cycle
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_we, data_we, data_re}));
  // R2: a select is always followed by a data cycle
  p_sel_then_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> (data_we || data_re));
  // R2: a data cycle always follows a select
  p_data_after_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we || data_re) |-> $past(addr_we));
  // R3: a failed halt check ends the run with code 1
  p_halt_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    halt_bad |=> (done && err_code == 2'd1));
  // R7: bound on reads in one run (halt check plus polls)
  p_read_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= 16'(POLL_LIMIT + 1));
  // R8: a seen completion flag is followed by a select cycle
  p_hit_then_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hit |=> addr_we);
  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: the result code is a defined value
  p_done_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code != 2'd3));
  // R10: busy only rises on a go
  p_start_on_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));
endmodule

bind nic_bringup_seq nbs_checker #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
  .err_code(err_code), .addr_we(port_addr_we), .data_we(port_data_we),
  .data_re(port_data_re), .halt_bad(halt_bad), .poll_hit(poll_hit)
);

// File: tb/nic_bringup_seq_tb.sv
module nic_bringup_seq_tb;
  localparam int LIMIT = 100;
  localparam int K_SEL = 1, K_WR = 2, K_RD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [31:0] init_addr = '0;
  logic        busy, done;
  logic [1:0]  err_code;
  logic        port_addr_we, port_data_we, port_data_re;
  logic [15:0] port_wdata;
  logic [15:0] port_rdata = '0;

  always #5 clk = ~clk;

  nic_bringup_seq u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .init_addr(init_addr),
    .busy(busy), .done(done), .err_code(err_code),
    .port_addr_we(port_addr_we), .port_data_we(port_data_we),
    .port_data_re(port_data_re), .port_wdata(port_wdata),
    .port_rdata(port_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int exp_q[$];
  int halt_resp, hit_at, flags, n_reads, cur_sel, done_seen;
  int wr_log[4];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // controller model: read data appears the cycle after the read strobe
  always @(posedge clk) begin
    if (port_data_re) begin
      n_reads <= n_reads + 1;
      if (n_reads == 0) port_rdata <= 16'(halt_resp);
      else if (hit_at != 0 && n_reads >= hit_at) port_rdata <= 16'(flags | 'h100);
      else port_rdata <= 16'(flags & ~'h100);
    end
  end

  // reference comparison of every port access
  always @(negedge clk) begin
    if (rst_n) begin
      if (port_addr_we || port_data_we || port_data_re) begin
        int kind, val, e;
        kind = port_addr_we ? K_SEL : (port_data_we ? K_WR : K_RD);
        val  = port_data_re ? 0 : int'(port_wdata);
        if (port_addr_we) cur_sel = int'(port_wdata[1:0]);
        if (port_data_we) wr_log[cur_sel] = val;
        if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected access", (kind << 16) | val, 0);
        else begin
          e = exp_q.pop_front();
          chk(e == ((kind << 16) | val), "R2", "access order/value", (kind << 16) | val, e);
        end
      end
      if (done) done_seen++;
    end
  end

  task automatic push(int kind, int val);
    exp_q.push_back((kind << 16) | val);
  endtask

  // hit: poll try number that sees bit 8 (0 = never)
  task automatic run(int addr, int hresp, int hit, int fl, bit go_mid, int exp_rc);
    int cyc;
    int n_poll;
    exp_q.delete();
    halt_resp = hresp; hit_at = hit; flags = fl; n_reads = 0;
    foreach (wr_log[i]) wr_log[i] = -1;
    init_addr = addr;
    push(K_SEL, 0); push(K_WR, 'h0004); push(K_SEL, 0); push(K_RD, 0);
    if (hresp == 'h0004) begin
      push(K_SEL, 1); push(K_WR, addr & 'hFFFF);
      push(K_SEL, 2); push(K_WR, 0);
      push(K_SEL, 3); push(K_WR, 'h0002);
      push(K_SEL, 0); push(K_WR, 'h0001);
      n_poll = (hit == 0 || hit > LIMIT) ? LIMIT : hit;
      for (int t = 0; t < n_poll; t++) begin push(K_SEL, 0); push(K_RD, 0); end
      if (hit != 0 && hit <= LIMIT) begin push(K_SEL, 0); push(K_WR, 'h0102); end
    end
    done_seen = 0;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      if (go_mid && cyc == 5) go = 1'b1;   // R10 stimulus while busy
      if (go_mid && cyc == 6) go = 1'b0;
      @(negedge clk); cyc++;
    end
    chk(cyc < 2000, "R9", "watchdog, done never seen", cyc, 0);
    chk(int'(err_code) == exp_rc, "R9", "result code", int'(err_code), exp_rc);
    @(negedge clk);
    chk(!done, "R9", "done longer than one cycle", int'(done), 0);
    chk(exp_q.size() == 0, "R3", "missing accesses", exp_q.size(), 0);
    chk(n_reads == ((hresp == 'h0004) ? 1 + n_poll : 1), "R7", "read count",
        n_reads, (hresp == 'h0004) ? 1 + n_poll : 1);
    if (exp_rc == 0) begin
      chk(wr_log[1] == (addr & 'hFFFF), "R4", "reg1 value", wr_log[1], addr & 'hFFFF);
      chk(wr_log[2] == 0, "R4", "reg2 value", wr_log[2], 0);
      chk(wr_log[3] == 'h0002, "R5", "reg3 value", wr_log[3], 2);
      chk(wr_log[0] == 'h0102, "R8", "final reg0 write", wr_log[0], 'h102);
    end
    repeat (3) @(negedge clk);
    chk(done_seen == 1, "R10", "done pulses in run", done_seen, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !port_addr_we && !port_data_we && !port_data_re,
        "R1", "idle after reset", {busy, done, port_addr_we, port_data_we, port_data_re}, 0);
    run(32'h1234_ABCD, 'h0004, 3, 'h0000, 1'b0, 0);   // R8 hit on third poll
    run(32'hFFFF_0010, 'h0005, 1, 'h0000, 1'b0, 1);   // R3 wrong read-back
    run(32'h0000_0000, 'h0084, 1, 'h0000, 1'b0, 1);   // R3 extra bit set
    run(32'h00C0_5A5A, 'h0004, 0, 'h8080, 1'b0, 2);   // R7 never completes
    run(32'h8765_4321, 'h0004, 1, 'hFEFF, 1'b0, 0);   // R6 other bits ignored
    run(32'h0BAD_F00D, 'h0004, LIMIT, 'h0000, 1'b0, 0); // R6 hit on last allowed try
    run(32'h0000_1234, 'h0004, 2, 'h0000, 1'b1, 0);   // R10 go while busy
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule